// File: doc/BRIEF.md
# Dual-Channel Wiper Step Controller

This block keeps the position codes of two digital potentiometer wipers and changes them on command. A single strobe carries an operation, a channel index, a data byte and two mode flags. The operations are: load a code directly, read a code back, step it linearly up or down by one, and step it by ±6 dB. A +6 dB step doubles the code and a −6 dB step halves it, which suits volume and brightness controls that need a steep, roughly logarithmic slope. Every modifying operation saturates at the ends of the range and never wraps.

The two channels answer to indices 1 and 3, so that software written for a four-channel part can drive this block unchanged. When both the synchronous-mode input and the both-channels flag are high, one command moves both wipers on the same clock edge. In asynchronous mode only the addressed wiper moves. The code width is a parameter: 6 bits gives 64 positions and 8 bits gives 256. Serial bus decoding and nonvolatile storage sit outside this block.

Top module: `wiper_step_ctrl`

## Requirements
- R1: After reset both wiper codes hold midscale (only the MSB set: 128 at 8 bits), and rd_valid and rd_data are 0.
- R2: Opcode 1 (write) loads cmd_data into the addressed wiper. The new code is visible on the wiper output one clock after the strobe.
- R3: Opcode 3 (increment) adds one to the addressed code and holds at full scale (all ones). It never wraps.
- R4: Opcode 4 (decrement) subtracts one from the addressed code and holds at zero. It never wraps.
- R5: Opcode 5 (+6 dB) doubles the code. A code with its MSB set goes to full scale, and a code of 0 becomes 1.
- R6: Opcode 6 (−6 dB) shifts the code right by one bit as a logical shift, so a code of 1 becomes 0.
- R7: Channel index 1 selects wiper_a and channel index 3 selects wiper_b.
- R8: With sync_mode=1 and cmd_both=1, a modifying command changes both wipers on the same clock edge, each from its own current code.
- R9: With sync_mode=0, cmd_both is ignored and only the wiper named by cmd_chan changes.
- R10: These commands leave both wipers unchanged: a command to channel index 0 or 2 without a synchronous both-channel request, opcode 0 (no-op), opcode 7 (reserved), and any cycle with cmd_valid low.
- R11: Opcode 2 (read) on index 1 or 3 sets rd_valid for one cycle, one clock after the strobe, with rd_data equal to that wiper's code. rd_valid and rd_data are 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Operation code |
| cmd_chan | input | 2 | Channel index (1 = A, 3 = B) |
| cmd_both | input | 1 | Apply to both channels (honoured in sync mode) |
| sync_mode | input | 1 | 1 = synchronous dual update, 0 = per-channel |
| cmd_data | input | CODE_W | Code for direct write |
| wiper_a | output | CODE_W | Current code of channel A |
| wiper_b | output | CODE_W | Current code of channel B |
| rd_valid | output | 1 | Readback result valid |
| rd_data | output | CODE_W | Readback code |

## Verification
Each wiper register drives its output pin directly, so a wrong next-code computation, a misdecoded channel or a wrong saturation appears on wiper_a or wiper_b one clock after the offending strobe. A fault in the readback path shows up on rd_valid and rd_data in that same following cycle. The scenarios push each step operation against both boundaries, and they check that the wiper not addressed stays still. Corruption in one channel therefore becomes visible immediately rather than after further commands.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_WRITE = 3'd1,
    OP_READ  = 3'd2,
    OP_INC   = 3'd3,
    OP_DEC   = 3'd4,
    OP_UP6   = 3'd5,
    OP_DN6   = 3'd6,
    OP_RSVD  = 3'd7
  } wsc_op_e;

  localparam int NUM_CH = 2;
  localparam logic [1:0] CH_IDX_A = 2'd1;
  localparam logic [1:0] CH_IDX_B = 2'd3;
endpackage

// File: rtl/wsc_decode.sv
module wsc_decode
  import wsc_pkg::*;
(
  input  logic                cmd_valid,
  input  wsc_op_e             op,
  input  logic [1:0]          chan,
  input  logic                both,
  input  logic                sync_mode,
  output logic [NUM_CH-1:0]   upd_en,
  output logic                rd_en,
  output logic                rd_sel_b
);
  logic modify_op;
  logic sel_a;
  logic sel_b;
  logic gang;

  always_comb begin
    modify_op = (op == OP_WRITE) || (op == OP_INC) || (op == OP_DEC) ||
                (op == OP_UP6)   || (op == OP_DN6);
    gang      = both && sync_mode;
    sel_a     = (chan == CH_IDX_A);
    sel_b     = (chan == CH_IDX_B);
    upd_en[0] = cmd_valid && modify_op && (sel_a || gang);
    upd_en[1] = cmd_valid && modify_op && (sel_b || gang);
    rd_en     = cmd_valid && (op == OP_READ) && (sel_a || sel_b);
    rd_sel_b  = sel_b;
  end
endmodule

// File: rtl/wsc_step_alu.sv
module wsc_step_alu
  import wsc_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  wsc_op_e           op,
  input  logic [CODE_W-1:0] cur,
  input  logic [CODE_W-1:0] wr_data,
  output logic [CODE_W-1:0] nxt
);
  localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] ZERO = '0;
  localparam logic [CODE_W-1:0] ONE  = {{(CODE_W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (op)
      OP_WRITE: nxt = wr_data;
      OP_INC:   nxt = (cur == FULL) ? FULL : cur + ONE;
      OP_DEC:   nxt = (cur == ZERO) ? ZERO : cur - ONE;
      OP_UP6: begin
        if (cur == ZERO)          nxt = ONE;
        else if (cur[CODE_W-1])   nxt = FULL;
        else                      nxt = {cur[CODE_W-2:0], 1'b0};
      end
      OP_DN6:   nxt = {1'b0, cur[CODE_W-1:1]};
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/wsc_readback.sv
module wsc_readback #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_sel_b,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  output logic              rd_valid,
  output logic [CODE_W-1:0] rd_data
);
  logic              valid_d;
  logic [CODE_W-1:0] data_d;

  always_comb begin
    valid_d = rd_en;
    data_d  = '0;
    if (rd_en) data_d = rd_sel_b ? code_b : code_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= valid_d;
      rd_data  <= data_d;
    end
  end
endmodule

// File: rtl/wiper_step_ctrl.sv
module wiper_step_ctrl
  import wsc_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [1:0]        cmd_chan,
  input  logic              cmd_both,
  input  logic              sync_mode,
  input  logic [CODE_W-1:0] cmd_data,
  output logic [CODE_W-1:0] wiper_a,
  output logic [CODE_W-1:0] wiper_b,
  output logic              rd_valid,
  output logic [CODE_W-1:0] rd_data
);
  localparam logic [CODE_W-1:0] MIDSCALE = {1'b1, {(CODE_W-1){1'b0}}};

  wsc_op_e            op;
  logic [NUM_CH-1:0]  upd_en;
  logic               rd_en;
  logic               rd_sel_b;
  logic [CODE_W-1:0]  code_q [NUM_CH];
  logic [CODE_W-1:0]  code_d [NUM_CH];
  logic [CODE_W-1:0]  step_v [NUM_CH];

  assign op = wsc_op_e'(cmd_op);

  wsc_decode u_dec (
    .cmd_valid (cmd_valid),
    .op        (op),
    .chan      (cmd_chan),
    .both      (cmd_both),
    .sync_mode (sync_mode),
    .upd_en    (upd_en),
    .rd_en     (rd_en),
    .rd_sel_b  (rd_sel_b)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    wsc_step_alu #(.CODE_W(CODE_W)) u_alu (
      .op      (op),
      .cur     (code_q[ch]),
      .wr_data (cmd_data),
      .nxt     (step_v[ch])
    );

    always_comb begin
      code_d[ch] = code_q[ch];
      if (upd_en[ch]) code_d[ch] = step_v[ch];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q[ch] <= MIDSCALE;
      else        code_q[ch] <= code_d[ch];
    end
  end

  assign wiper_a = code_q[0];
  assign wiper_b = code_q[1];

  wsc_readback #(.CODE_W(CODE_W)) u_rb (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_sel_b (rd_sel_b),
    .code_a   (code_q[0]),
    .code_b   (code_q[1]),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/wsc_checker.sv
module wsc_checker #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [1:0]        cmd_chan,
  input logic              cmd_both,
  input logic              sync_mode,
  input logic [CODE_W-1:0] cmd_data,
  input logic [CODE_W-1:0] wiper_a,
  input logic [CODE_W-1:0] wiper_b,
  input logic              rd_valid,
  input logic [CODE_W-1:0] rd_data
);
  localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] MID  = {1'b1, {(CODE_W-1){1'b0}}};

  logic hit_a;
  assign hit_a = cmd_valid && (cmd_chan == 2'd1 || (cmd_both && sync_mode));

  p_reset_mid_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (wiper_a == MID && wiper_b == MID && !rd_valid));

  p_write_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && cmd_op == 3'd1) |=> (wiper_a == $past(cmd_data)));

  p_inc_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && cmd_op == 3'd3 && wiper_a != FULL) |=> (wiper_a == $past(wiper_a) + 1'b1));

  p_dec_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && cmd_op == 3'd4 && wiper_a == '0) |=> (wiper_a == '0));

  p_halve_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && cmd_op == 3'd6) |=> (wiper_a == ($past(wiper_a) >> 1)));

  p_async_other_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !sync_mode && cmd_chan == 2'd1) |=> $stable(wiper_b));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid) |=> ($stable(wiper_a) && $stable(wiper_b)));

  p_bad_chan_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !(cmd_both && sync_mode) && cmd_chan[0] == 1'b0)
      |=> ($stable(wiper_a) && $stable(wiper_b)));

  p_read_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2 && cmd_chan == 2'd3)
      |=> (rd_valid && rd_data == $past(wiper_b)));

  p_read_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid) |=> (!rd_valid && rd_data == '0));
endmodule

bind wiper_step_ctrl wsc_checker #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_chan  (cmd_chan),
  .cmd_both  (cmd_both),
  .sync_mode (sync_mode),
  .cmd_data  (cmd_data),
  .wiper_a   (wiper_a),
  .wiper_b   (wiper_b),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data)
);

// File: tb/wiper_step_ctrl_tb_top.sv
module wiper_step_ctrl_tb_top;
  localparam int W = 8;
  localparam logic [W-1:0] FULL = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [2:0]   cmd_op = 3'd0;
  logic [1:0]   cmd_chan = 2'd0;
  logic         cmd_both = 1'b0;
  logic         sync_mode = 1'b0;
  logic [W-1:0] cmd_data = '0;
  logic [W-1:0] wiper_a, wiper_b, rd_data;
  logic         rd_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [W-1:0] m_a, m_b;
  logic [W-1:0] q_a[$], q_b[$], q_rd[$];
  logic         q_rv[$];
  string        q_tag[$];

  always #2 clk = ~clk;

  wiper_step_ctrl #(.CODE_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_chan(cmd_chan), .cmd_both(cmd_both), .sync_mode(sync_mode),
    .cmd_data(cmd_data), .wiper_a(wiper_a), .wiper_b(wiper_b),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [W-1:0] model_step(input logic [2:0] op,
                                               input logic [W-1:0] c,
                                               input logic [W-1:0] d);
    case (op)
      3'd1: return d;
      3'd3: return (c == FULL) ? FULL : c + 1'b1;
      3'd4: return (c == '0) ? '0 : c - 1'b1;
      3'd5: begin
        if (c == '0) return 1;
        if (c >= 8'd128) return FULL;
        return c * 2;
      end
      3'd6: return c / 2;
      default: return c;
    endcase
  endfunction

  task automatic send(input logic [2:0] op, input logic [1:0] ch,
                      input logic both, input logic syn,
                      input logic [W-1:0] d, input string tag);
    logic gang, ea, eb, is_mod, rv;
    logic [W-1:0] rd;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_chan = ch; cmd_both = both;
    sync_mode = syn; cmd_data = d;
    gang   = both && syn;
    is_mod = (op == 3'd1) || (op >= 3'd3 && op <= 3'd6);
    ea = is_mod && (ch == 2'd1 || gang);
    eb = is_mod && (ch == 2'd3 || gang);
    rv = (op == 3'd2) && (ch == 2'd1 || ch == 2'd3);
    rd = rv ? ((ch == 2'd3) ? m_b : m_a) : '0;
    if (ea) m_a = model_step(op, m_a, d);
    if (eb) m_b = model_step(op, m_b, d);
    q_a.push_back(m_a); q_b.push_back(m_b);
    q_rv.push_back(rv); q_rd.push_back(rd); q_tag.push_back(tag);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    if (q_a.size() > 0) begin
      logic [W-1:0] ea, eb, er;
      logic ev;
      string t;
      ea = q_a.pop_front(); eb = q_b.pop_front();
      ev = q_rv.pop_front(); er = q_rd.pop_front(); t = q_tag.pop_front();
      n_checks++;
      if (wiper_a !== ea || wiper_b !== eb || rd_valid !== ev || rd_data !== er) begin
        n_fail++;
        $display("FAIL %s: got a=%0d b=%0d rv=%0b rd=%0d, expected a=%0d b=%0d rv=%0b rd=%0d",
                 t, wiper_a, wiper_b, rd_valid, rd_data, ea, eb, ev, er);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    m_a = 8'd128; m_b = 8'd128;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (wiper_a !== 8'd128 || wiper_b !== 8'd128 || rd_valid !== 1'b0 || rd_data !== '0) begin
      n_fail++;
      $display("FAIL R1 reset: got a=%0d b=%0d rv=%0b, expected 128 128 0",
               wiper_a, wiper_b, rd_valid);
    end
    // R2, R7: direct writes to index 1 and 3
    send(3'd1, 2'd1, 1'b0, 1'b0, 8'd5,   "R2 R7 write A");
    send(3'd1, 2'd3, 1'b0, 1'b0, 8'd200, "R2 R7 write B");
    // R11 readback
    send(3'd2, 2'd1, 1'b0, 1'b0, 8'd0, "R11 read A");
    send(3'd2, 2'd3, 1'b0, 1'b0, 8'd0, "R11 read B");
    send(3'd2, 2'd2, 1'b0, 1'b0, 8'd0, "R11 read bad index");
    // R3 increment and ceiling
    send(3'd3, 2'd1, 1'b0, 1'b0, 8'd0,   "R3 inc A");
    send(3'd1, 2'd1, 1'b0, 1'b0, 8'd254, "R2 write A 254");
    send(3'd3, 2'd1, 1'b0, 1'b0, 8'd0,   "R3 inc to full");
    send(3'd3, 2'd1, 1'b0, 1'b0, 8'd0,   "R3 inc saturate");
    // R4 decrement and floor
    send(3'd4, 2'd3, 1'b0, 1'b0, 8'd0, "R4 dec B");
    send(3'd1, 2'd3, 1'b0, 1'b0, 8'd1, "R2 write B 1");
    send(3'd4, 2'd3, 1'b0, 1'b0, 8'd0, "R4 dec to zero");
    send(3'd4, 2'd3, 1'b0, 1'b0, 8'd0, "R4 dec floor");
    // R5 doubling
    send(3'd5, 2'd3, 1'b0, 1'b0, 8'd0,   "R5 up from zero");
    send(3'd5, 2'd3, 1'b0, 1'b0, 8'd0,   "R5 up 1->2");
    send(3'd1, 2'd3, 1'b0, 1'b0, 8'd100, "R2 write B 100");
    send(3'd5, 2'd3, 1'b0, 1'b0, 8'd0,   "R5 up 100->200");
    send(3'd5, 2'd3, 1'b0, 1'b0, 8'd0,   "R5 up saturate");
    send(3'd1, 2'd1, 1'b0, 1'b0, 8'd127, "R2 write A 127");
    send(3'd5, 2'd1, 1'b0, 1'b0, 8'd0,   "R5 up 127->254");
    // R6 halving
    send(3'd6, 2'd1, 1'b0, 1'b0, 8'd0, "R6 down 254->127");
    send(3'd6, 2'd1, 1'b0, 1'b0, 8'd0, "R6 down odd");
    send(3'd1, 2'd1, 1'b0, 1'b0, 8'd1, "R2 write A 1");
    send(3'd6, 2'd1, 1'b0, 1'b0, 8'd0, "R6 down 1->0");
    send(3'd6, 2'd1, 1'b0, 1'b0, 8'd0, "R6 down zero");
    // R8 synchronous dual update
    send(3'd1, 2'd0, 1'b1, 1'b1, 8'd77, "R8 sync write both");
    send(3'd3, 2'd1, 1'b1, 1'b1, 8'd0,  "R8 sync inc both");
    send(3'd1, 2'd3, 1'b0, 1'b0, 8'd3,  "R2 write B 3");
    send(3'd5, 2'd2, 1'b1, 1'b1, 8'd0,  "R8 sync up both");
    // R9 asynchronous: both flag ignored
    send(3'd1, 2'd1, 1'b1, 1'b0, 8'd10, "R9 async write A only");
    send(3'd4, 2'd3, 1'b1, 1'b0, 8'd0,  "R9 async dec B only");
    send(3'd1, 2'd0, 1'b1, 1'b0, 8'd9,  "R9 R10 async bad index");
    // R10 ignored commands
    send(3'd1, 2'd0, 1'b0, 1'b1, 8'd33, "R10 write index 0");
    send(3'd1, 2'd2, 1'b0, 1'b0, 8'd44, "R10 write index 2");
    send(3'd7, 2'd1, 1'b0, 1'b0, 8'd55, "R10 reserved op");
    send(3'd0, 2'd3, 1'b1, 1'b1, 8'd66, "R10 nop");
    send(3'd2, 2'd1, 1'b0, 1'b0, 8'd0,  "R10 R11 read after ignored");
    send(3'd2, 2'd3, 1'b1, 1'b1, 8'd0,  "R10 R11 read B after ignored");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule